// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This controller sits between a clocked host and an asynchronous 512K x 8 static RAM. The host issues one read or one write at a time on a valid/ready port. The controller then produces the RAM's strobes: two chip selects of opposite polarity, an output enable and a write enable. It also drives the write data through a tri-state driver that has its own enable. Each strobe phase lasts a whole number of clock cycles. Those counts are worked out at elaboration as the ceiling of a nanosecond limit divided by the clock period, so one parameter set serves any clock.

A write holds the RAM selected and output enable high. Write enable is then pulled low. The data driver turns on only after the RAM has had time to release the bus. The write ends when write enable rises while the chip selects are still active. A read holds output enable low for the access time and captures the bus in the final cycle. Both kinds of access end with a one-cycle completion pulse.

Top module: `async_sram_ctrl`

## Requirements
- R1: While `req_ready` is high, the memory side is idle: `mem_cs_n`=1, `mem_cs`=0, `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0. This idle state holds after reset.
- R2: During an access, from the first cycle after acceptance to the last cycle before completion, the RAM is selected (`mem_cs_n`=0 together with `mem_cs`=1). `mem_addr` holds the accepted address throughout.
- R3: A write (`req_we`=1) holds `mem_we_n` low for NWL cycles, where NWL = max(ceil(T_PWE/CLK), ceil(T_AW/CLK), ceil(T_HZ/CLK)+ceil(T_SD/CLK)). That is 9 cycles at a 5 ns clock. `mem_oe_n` stays high, and `mem_dq_out` holds the accepted data from the first low cycle through the first cycle after write enable rises.
- R4: The data driver `mem_dq_oe` turns on after write enable has been low for ceil(T_HZ/CLK) cycles (4 at 5 ns). It stays on through the first cycle with write enable high, and is off in the cycle after that. It is never on while `mem_oe_n` is low.
- R5: A write ends by `mem_we_n` rising while the RAM is still selected. The RAM stays selected for max(1, ceil(T_WC/CLK)-NWL) cycles in total after that rise (2 at 5 ns).
- R6: A read (`req_we`=0) holds `mem_oe_n` low and `mem_we_n` high for NRD = max(ceil(T_RC/CLK), ceil(T_AA/CLK), ceil(T_DOE/CLK)) cycles (11 at 5 ns). `rsp_rdata` takes the value present on `mem_dq_in` during the last of those cycles.
- R7: `req_ready` is low from the cycle after acceptance until the access completes. `rsp_done` is high for exactly one cycle, the first cycle in which `req_ready` is high again.
- R8: If synchronous reset arrives during a write, `mem_we_n` is high one clock later while the RAM is still selected. The chip selects go inactive one clock after that.
- R9: Request inputs that change while `req_ready` is low have no effect on `mem_addr` or on the data driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (19) | Request address |
| req_wdata | input | DW (8) | Write data |
| rsp_rdata | output | DW (8) | Captured read data |
| rsp_done | output | 1 | One-cycle completion pulse |
| mem_addr | output | AW (19) | RAM address |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_cs | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_dq_out | output | DW (8) | Data toward the RAM |
| mem_dq_oe | output | 1 | Enable for the data driver |
| mem_dq_in | input | DW (8) | Data from the RAM |

## Verification
The bench writes and reads back complementary byte patterns (A5/5A, FF/00, 3C) at addresses whose high and low bits differ. This catches swapped or stuck data and address lines. A RAM model in the bench drives valid read data only from the 11th cycle of output enable low, so a read phase that is one cycle short returns the wrong byte. Each access is compared cycle by cycle against the computed phase lengths. This separates early or late write-enable release, driver turn-on, chip-select release and completion. Request inputs are changed while the controller is busy, and a reset is forced in the middle of a write to check the order in which the strobes fall away.

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl #(
  parameter int CLK_NS = 10,
  parameter int AW     = 19,
  parameter int DW     = 8,
  parameter int T_WC   = 55,
  parameter int T_PWE  = 40,
  parameter int T_AW   = 45,
  parameter int T_SD   = 25,
  parameter int T_RC   = 55,
  parameter int T_AA   = 55,
  parameter int T_DOE  = 35,
  parameter int T_HZ   = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_done,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs_n,
  output logic          mem_cs,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);

  localparam int C_HZ  = (T_HZ  + CLK_NS - 1) / CLK_NS;
  localparam int C_SD  = (T_SD  + CLK_NS - 1) / CLK_NS;
  localparam int C_PWE = (T_PWE + CLK_NS - 1) / CLK_NS;
  localparam int C_AW  = (T_AW  + CLK_NS - 1) / CLK_NS;
  localparam int C_WC  = (T_WC  + CLK_NS - 1) / CLK_NS;
  localparam int C_RC  = (T_RC  + CLK_NS - 1) / CLK_NS;
  localparam int C_AA  = (T_AA  + CLK_NS - 1) / CLK_NS;
  localparam int C_DOE = (T_DOE + CLK_NS - 1) / CLK_NS;

  localparam int N_HZ  = (C_HZ < 1) ? 1 : C_HZ;
  localparam int N_W1  = (C_PWE > C_AW) ? C_PWE : C_AW;
  localparam int N_W2  = N_HZ + ((C_SD < 1) ? 1 : C_SD);
  localparam int N_WL  = (N_W1 > N_W2) ? N_W1 : N_W2;
  localparam int N_REC = (C_WC > N_WL) ? C_WC - N_WL : 1;
  localparam int N_R1  = (C_RC > C_AA) ? C_RC : C_AA;
  localparam int N_R2  = (N_R1 > C_DOE) ? N_R1 : C_DOE;
  localparam int N_RD  = (N_R2 < 1) ? 1 : N_R2;
  localparam int N_MAX = (N_WL > N_RD) ? ((N_WL > N_REC) ? N_WL : N_REC) : N_RD;
  localparam int CW    = $clog2(N_MAX + 1);

  typedef enum logic [1:0] {S_IDLE, S_WLOW, S_WREC, S_READ} state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic          sel;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] rdata_q;

  assign req_ready  = (state == S_IDLE) && !sel;
  assign mem_cs_n   = !sel;
  assign mem_cs     = sel;
  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign rsp_rdata  = rdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
      rsp_done  <= 1'b0;
      sel       <= sel && !mem_we_n;
    end else begin
      rsp_done <= 1'b0;
      case (state)
        S_IDLE: begin
          sel <= 1'b0;
          if (req_valid && !sel) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            sel     <= 1'b1;
            cnt     <= '0;
            if (req_we) begin
              mem_we_n <= 1'b0;
              state    <= S_WLOW;
            end else begin
              mem_oe_n <= 1'b0;
              state    <= S_READ;
            end
          end
        end
        S_WLOW: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(N_HZ - 1)) mem_dq_oe <= 1'b1;
          if (cnt == CW'(N_WL - 1)) begin
            mem_we_n <= 1'b1;
            cnt      <= '0;
            state    <= S_WREC;
          end
        end
        S_WREC: begin
          mem_dq_oe <= 1'b0;
          cnt       <= cnt + 1'b1;
          if (cnt == CW'(N_REC - 1)) begin
            sel      <= 1'b0;
            rsp_done <= 1'b1;
            state    <= S_IDLE;
          end
        end
        default: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(N_RD - 1)) begin
            rdata_q  <= mem_dq_in;
            mem_oe_n <= 1'b1;
            sel      <= 1'b0;
            rsp_done <= 1'b1;
            state    <= S_IDLE;
          end
        end
      endcase
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && !mem_cs && mem_we_n && mem_oe_n && !mem_dq_oe)); // R1
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && $past(sel)) |-> $stable(mem_addr)); // R2
  AST_WE_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_cs_n && mem_cs && mem_oe_n)); // R3
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n); // R4
  AST_DRV_OFF_AFTER_WE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |=> !mem_dq_oe); // R4
  AST_WE_ENDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (!mem_cs_n && mem_cs)); // R5
  AST_DONE_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> req_ready); // R7

endmodule

// File: tb/tb_async_sram_ctrl.sv
`timescale 1ns/1ps
module tb_async_sram_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_we, req_ready, rsp_done;
  logic [18:0] req_addr, mem_addr;
  logic [7:0]  req_wdata, rsp_rdata, mem_dq_out, mem_dq_in;
  logic        mem_cs_n, mem_cs, mem_oe_n, mem_we_n, mem_dq_oe;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  async_sram_ctrl #(.CLK_NS(5)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .rsp_done(rsp_done), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_cs(mem_cs), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  logic [7:0] marr [0:255];
  logic [7:0] shadow [0:255];
  logic       prev_we = 1'b1;
  int         rcnt = 0;
  wire        m_sel = !mem_cs_n && mem_cs;

  always @(posedge clk) begin
    prev_we <= mem_we_n;
    if (!prev_we && mem_we_n && m_sel && mem_dq_oe) marr[mem_addr[7:0]] <= mem_dq_out;
    if (m_sel && !mem_oe_n && mem_we_n) rcnt <= rcnt + 1;
    else rcnt <= 0;
  end

  assign mem_dq_in = (m_sel && !mem_oe_n && mem_we_n && rcnt >= 10) ? marr[mem_addr[7:0]] : 8'hEE;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic bit idle_pins();
    return mem_cs_n && !mem_cs && mem_we_n && mem_oe_n && !mem_dq_oe;
  endfunction

  task automatic do_write(input logic [18:0] a, input logic [7:0] d);
    int e1 = 0, e2 = 0, e3 = 0, e4 = 0, e5 = 0, e7 = 0, e9 = 0;
    @(negedge clk);
    chk(req_ready, "R1 ready before write", req_ready, 1);
    req_valid = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk);
    for (int k = 0; k <= 12; k++) begin
      @(negedge clk);
      if (k <= 10) begin
        if (!(m_sel)) e2++;
        if (req_ready) e7++;
        if (mem_addr != a) e9++;
      end
      if (k <= 8 && !(mem_we_n == 1'b0 && mem_oe_n && mem_dq_out == d)) e3++;
      if (k == 9 && mem_dq_out != d) e3++;
      if (k <= 10 && mem_dq_oe != (k >= 4 && k <= 9)) e4++;
      if ((k == 9 || k == 10) && !(mem_we_n && m_sel)) e5++;
      if (k == 11 && m_sel) e5++;
      if (k >= 11 && !(req_ready && idle_pins())) e1++;
      if (rsp_done != (k == 11)) e7++;
      if (k == 0) begin req_addr = ~a; req_wdata = ~d; end
      if (k == 10) req_valid = 1'b0;
    end
    shadow[a[7:0]] = d;
    chk(e1 == 0, "R1 idle after write", e1, 0);
    chk(e2 == 0, "R2 selected during write", e2, 0);
    chk(e3 == 0, "R3 write enable phase", e3, 0);
    chk(e4 == 0, "R4 driver window", e4, 0);
    chk(e5 == 0, "R5 write end order", e5, 0);
    chk(e7 == 0, "R7 ready/done on write", e7, 0);
    chk(e9 == 0, "R9 busy inputs ignored", e9, 0);
  endtask

  task automatic do_read(input logic [18:0] a);
    int e2 = 0, e6 = 0, e7 = 0, e4 = 0;
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_addr = a;
    @(posedge clk);
    for (int k = 0; k <= 12; k++) begin
      @(negedge clk);
      if (k <= 10) begin
        if (!m_sel || mem_addr != a) e2++;
        if (!(mem_oe_n == 1'b0 && mem_we_n)) e6++;
        if (mem_dq_oe) e4++;
        if (req_ready) e7++;
      end
      if (k == 11 && !(req_ready && idle_pins())) e7++;
      if (rsp_done != (k == 11)) e7++;
      if (k == 10) req_valid = 1'b0;
    end
    chk(e2 == 0, "R2 selected during read", e2, 0);
    chk(e4 == 0, "R4 driver off in read", e4, 0);
    chk(e6 == 0, "R6 read strobe phase", e6, 0);
    chk(rsp_rdata == shadow[a[7:0]], "R6 read data", rsp_rdata, shadow[a[7:0]]);
    chk(e7 == 0, "R7 ready/done on read", e7, 0);
  endtask

  task automatic reset_mid_write(input logic [18:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk); req_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(mem_we_n == 1'b0, "R8 write active before reset", mem_we_n, 0);
    rst_n = 1'b0;
    @(negedge clk);
    chk(mem_we_n == 1'b1, "R8 we released first", mem_we_n, 1);
    chk(m_sel, "R8 select held one clock", m_sel, 1);
    @(negedge clk);
    chk(!m_sel, "R8 select dropped", m_sel, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && idle_pins(), "R1 idle after abort", req_ready, 1);
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin marr[i] = 8'h00; shadow[i] = 8'h00; end
    rst_n = 1'b0; req_valid = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && idle_pins() && !rsp_done, "R1 reset state", req_ready, 1);
    do_write(19'h00012, 8'hA5);
    do_write(19'h7FF34, 8'h5A);
    do_read(19'h00012);
    do_read(19'h7FF34);
    do_write(19'h40056, 8'hFF);
    do_write(19'h00078, 8'h00);
    do_read(19'h40056);
    do_read(19'h00078);
    do_write(19'h00012, 8'h3C);
    do_read(19'h00012);
    reset_mid_write(19'h00099, 8'h77);
    do_read(19'h7FF34);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule